// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block is the slave end of a stereo serial audio link. The link has three wires: a bit clock, a frame clock whose level says which channel is being sent, and one data line. The block runs directly on the bit clock, so the bit clock is its `clk_i`. Each rising edge takes one data bit. A 3-bit format select picks one of five framings:

- MSB-justified 24-bit.
- I2S-style 24-bit, where the MSB comes one slot late.
- LSB-justified with 16, 20 or 24 bits, where the word ends at the last slot of each half-frame.

Because the LSB-justified words are located by counting back from the end of each half, the block does not need to know the half-frame length in advance. The 16-bit mode therefore works with both 32-slot and 16-slot halves.

For each complete stereo frame the block gives out one signed 24-bit left sample and one signed 24-bit right sample. Shorter words are left-aligned and padded with zeros in the low bits. Both samples appear together with a single one-cycle valid pulse. That pulse comes after the right half has ended.

Top module: `audio_ser_rx`

## Requirements
- R1: While `rst_ni` is low at a rising edge, and after that edge, `valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: With `fmt_i` = 010 (MSB-justified, the reset default), a half-frame's word is the 24 bits in slots 0..23, where slot 0 is the first rising edge after a frame-clock change and the first bit taken is the MSB. Frame clock high carries the left channel.
- R3: With `fmt_i` = 011 (I2S-style), the word occupies slots 1..24, and frame clock low carries the left channel.
- R4: With `fmt_i` = 100 (24-bit LSB-justified), the word is the last 24 slots of each half, and the last slot is the LSB. Frame clock high is left.
- R5: With `fmt_i` = 001 (20-bit LSB-justified), the word is the last 20 slots of the half. It is output in bits 23:4, and bits 3:0 are zero.
- R6: With `fmt_i` = 000 (16-bit LSB-justified) and 32-slot halves, the word is the last 16 slots. It is output in bits 23:8, and bits 7:0 are zero.
- R7: Format 000 also decodes correctly with 16-slot halves (a 32-bit-clock frame).
- R8: Slots outside a format's word window have no effect on the samples, whatever their values.
- R9: The unused codes 101, 110 and 111 decode exactly like 010.
- R10: `valid_o` is high for exactly one cycle per stereo frame. It rises in the cycle after the rising edge that samples the first slot of the half following the right half. `left_o` and `right_o` change only together with that pulse.
- R11: The half-frame that is in progress when reset is released is never published. A pulse needs a left half and then a right half, each starting and ending with a frame-clock change seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data sampled on its rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| lrclk_i | input | 1 | Frame clock; its level selects the channel |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_i | input | 3 | Framing select (see R2 to R9) |
| left_o | output | 24 | Left sample, left-aligned signed |
| right_o | output | 24 | Right sample, left-aligned signed |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The properties assume three things about the inputs:

- The frame clock and the data line are steady at every rising bit-clock edge. The bench meets this by changing both only on the falling edge.
- The format select stays constant across the halves that feed a published pair.
- The padding checks look only at the right sample, which is decoded at the same edge as the pulse.

The bench changes `fmt_i` only between scenarios. It opens each scenario with a lead-in half, so any pair that straddles a format change is later overwritten and never checked.

// File: rtl/ars_pkg.sv
// Package: shared constants and the framing decode for the audio serial receiver.
// Assumes the full sample width is at least the widest short word.
package ars_pkg;

    localparam int unsigned SMP_W   = 24;  // output sample width
    localparam int unsigned SHORT_W = 16;  // shortest LSB-justified word
    localparam int unsigned MID_W   = 20;  // middle LSB-justified word

    typedef enum logic [2:0] {
        FMT_RJ16 = 3'd0,
        FMT_RJ20 = 3'd1,
        FMT_LJ24 = 3'd2,
        FMT_I2S  = 3'd3,
        FMT_RJ24 = 3'd4
    } fmt_e;

    // Map the raw select onto a framing; unused codes fall back to the default.
    function automatic fmt_e decode_fmt(input logic [2:0] code);
        case (code)
            3'd0:    return FMT_RJ16;
            3'd1:    return FMT_RJ20;
            3'd3:    return FMT_I2S;
            3'd4:    return FMT_RJ24;
            default: return FMT_LJ24;
        endcase
    endfunction

endpackage

// File: rtl/ars_slot_tracker.sv
// Slot tracker: finds frame-clock changes and numbers the slots within a half.
// Assumes the frame clock is steady at every rising edge of clk_i.
// The first cycle after reset only loads the previous level, so the level
// present at reset release is never mistaken for a change.
module ars_slot_tracker #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lrclk_i,
    output logic             edge_o,
    output logic             full_o,
    output logic             lr_prev_o,
    output logic [CNT_W-1:0] slot_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             primed_q;
    logic             synced_q;
    logic             lr_q;
    logic [CNT_W-1:0] cnt_q;

    // A change is only valid once a previous level has been loaded.
    assign edge_o    = primed_q && (lrclk_i != lr_q);
    assign full_o    = edge_o && synced_q;
    assign lr_prev_o = lr_q;
    assign slot_o    = edge_o ? '0 : cnt_q;

    // Track the previous level, the sync state and the saturating slot count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            primed_q <= 1'b0;
            synced_q <= 1'b0;
            lr_q     <= 1'b0;
            cnt_q    <= '0;
        end else begin
            primed_q <= 1'b1;
            lr_q     <= lrclk_i;
            if (edge_o) begin
                synced_q <= 1'b1;
                cnt_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
            end else if (cnt_q != CNT_MAX) begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ars_word_shifter.sv
// Word shifter: collects serial bits and gives out the aligned word of the
// half that has just ended. LSB-justified words are read from the tail of the
// shift register at the half boundary. MSB-first windows are snapshotted as
// soon as their last slot arrives.
module ars_word_shifter
    import ars_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sdata_i,
    input  logic [CNT_W-1:0] slot_i,
    input  fmt_e             fmt_i,
    output logic [SMP_W-1:0] word_o
);

    localparam logic [CNT_W-1:0] LJ_LAST  = CNT_W'(SMP_W - 1);
    localparam logic [CNT_W-1:0] I2S_LAST = CNT_W'(SMP_W);

    logic [SMP_W-1:0] sh_q;
    logic [SMP_W-1:0] snap_q;
    logic             snap_en;

    // Snapshot when the last bit of an MSB-first window is being sampled.
    assign snap_en = ((fmt_i == FMT_LJ24) && (slot_i == LJ_LAST)) ||
                     ((fmt_i == FMT_I2S)  && (slot_i == I2S_LAST));

    // Shift every bit in and keep the MSB-first snapshot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh_q   <= '0;
            snap_q <= '0;
        end else begin
            sh_q <= {sh_q[SMP_W-2:0], sdata_i};
            if (snap_en) begin
                snap_q <= {sh_q[SMP_W-2:0], sdata_i};
            end
        end
    end

    // Select and left-align the word for the half that closes at this edge.
    always_comb begin
        case (fmt_i)
            FMT_RJ16: word_o = {sh_q[SHORT_W-1:0], {(SMP_W-SHORT_W){1'b0}}};
            FMT_RJ20: word_o = {sh_q[MID_W-1:0],   {(SMP_W-MID_W){1'b0}}};
            FMT_RJ24: word_o = sh_q;
            default:  word_o = snap_q;
        endcase
    end

endmodule

// File: rtl/ars_frame_pack.sv
// Frame pack: holds the left word and publishes the stereo pair with a single
// strobe once the matching right half has closed.
// Assumes full_i is raised only for halves that were seen from start to end.
module ars_frame_pack
    import ars_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             full_i,
    input  logic             lr_prev_i,
    input  fmt_e             fmt_i,
    input  logic [SMP_W-1:0] word_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             valid_o
);

    logic             left_lvl;
    logic             was_left;
    logic             have_left_q;
    logic [SMP_W-1:0] left_hold_q;

    // The I2S framing uses a low frame clock for the left channel.
    assign left_lvl = (fmt_i != FMT_I2S);
    assign was_left = (lr_prev_i == left_lvl);

    // Store the left word; publish it together with the right word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            have_left_q <= 1'b0;
            left_hold_q <= '0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (full_i) begin
                if (was_left) begin
                    left_hold_q <= word_i;
                    have_left_q <= 1'b1;
                end else begin
                    have_left_q <= 1'b0;
                    if (have_left_q) begin
                        left_o  <= left_hold_q;
                        right_o <= word_i;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/audio_ser_rx.sv
// Top level: multi-format stereo serial audio receiver clocked by the bit clock.
// Assumes the frame clock and data are steady at each rising clock edge and that
// the format select changes only while no frame of interest is in flight.
module audio_ser_rx
    import ars_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lrclk_i,
    input  logic             sdata_i,
    input  logic [2:0]       fmt_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             valid_o
);

    fmt_e             fmt;
    logic             lr_edge;
    logic             half_full;
    logic             lr_prev;
    logic [CNT_W-1:0] slot;
    logic [SMP_W-1:0] word;

    assign fmt = decode_fmt(fmt_i);

    ars_slot_tracker #(.CNT_W(CNT_W)) tracker_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lrclk_i   (lrclk_i),
        .edge_o    (lr_edge),
        .full_o    (half_full),
        .lr_prev_o (lr_prev),
        .slot_o    (slot)
    );

    ars_word_shifter #(.CNT_W(CNT_W)) shifter_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sdata_i (sdata_i),
        .slot_i  (slot),
        .fmt_i   (fmt),
        .word_o  (word)
    );

    ars_frame_pack pack_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .full_i    (half_full),
        .lr_prev_i (lr_prev),
        .fmt_i     (fmt),
        .word_i    (word),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o)
    );

    // The tracker's raw edge flag is consumed only through half_full.
    logic unused_edge;
    assign unused_edge = lr_edge;

endmodule

// File: rtl/ars_checker.sv
// Checker: temporal properties of the receiver, observed at its ports.
// It keeps its own count of frame-clock changes since reset.
module ars_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        lrclk_i,
    input logic [2:0]  fmt_i,
    input logic [23:0] left_o,
    input logic [23:0] right_o,
    input logic        valid_o
);

    logic       primed_q;
    logic       lr_q;
    logic [1:0] changes_q;

    // Count frame-clock changes since reset, saturating at three.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            primed_q  <= 1'b0;
            lr_q      <= 1'b0;
            changes_q <= 2'd0;
        end else begin
            primed_q <= 1'b1;
            lr_q     <= lrclk_i;
            if (primed_q && (lrclk_i != lr_q) && (changes_q != 2'd3)) begin
                changes_q <= changes_q + 2'd1;
            end
        end
    end

    // R10
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R10
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R11
    no_early_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (changes_q == 2'd3));

    // R5
    pad20_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ($past(fmt_i) == 3'b001)) |-> (right_o[3:0] == 4'h0));

    // R6
    pad16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ($past(fmt_i) == 3'b000)) |-> (right_o[7:0] == 8'h00));

endmodule

bind audio_ser_rx ars_checker chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lrclk_i (lrclk_i),
    .fmt_i   (fmt_i),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
);

// File: tb/audio_ser_rx_tb.sv
// Directed bench for the audio serial receiver. Inputs change on the falling
// edge; results are read on the falling edge.
module audio_ser_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrclk = 1'b1;
    logic        sdata = 1'b0;
    logic [2:0]  fmt = 3'b010;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int          tests = 0;
    int          fails = 0;
    int          vcount = 0;
    logic [23:0] got_l = '0;
    logic [23:0] got_r = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    audio_ser_rx dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .lrclk_i (lrclk),
        .sdata_i (sdata),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    // Latch every published pair away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            vcount = vcount + 1;
            got_l  = left_o;
            got_r  = right_o;
        end
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic left_lvl(input logic [2:0] f);
        return (f == 3'b011) ? 1'b0 : 1'b1;
    endfunction

    // Bit placed in slot s of an n-slot half for framing f.
    function automatic logic slot_bit(input logic [2:0] f, input logic [23:0] w,
                                      input int n, input int s, input logic junk);
        case (f)
            3'b000:  return (s >= n - 16) ? w[15 - (s - (n - 16))] : junk;
            3'b001:  return (s >= n - 20) ? w[19 - (s - (n - 20))] : junk;
            3'b100:  return (s >= n - 24) ? w[23 - (s - (n - 24))] : junk;
            3'b011:  return (s >= 1 && s < 25) ? w[23 - (s - 1)] : junk;
            default: return (s < 24) ? w[23 - s] : junk;
        endcase
    endfunction

    function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
        case (f)
            3'b000:  return {w[15:0], 8'h00};
            3'b001:  return {w[19:0], 4'h0};
            default: return w;
        endcase
    endfunction

    task automatic drive_half(input logic lvl, input logic [23:0] w, input logic [2:0] f,
                              input int n, input logic junk);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            lrclk = lvl;
            sdata = slot_bit(f, w, n, s, junk);
        end
    endtask

    // One stereo frame between a lead-in half and a closing half, then compare.
    task automatic frame_test(input string req, input logic [2:0] f, input logic [23:0] l,
                              input logic [23:0] r, input int n, input logic junk);
        logic ll;
        ll = left_lvl(f);
        @(negedge clk);
        fmt = f;
        drive_half(~ll, 24'h0, f, n, 1'b0);
        drive_half(ll, l, f, n, junk);
        drive_half(~ll, r, f, n, junk);
        drive_half(ll, 24'h0, f, n, 1'b0);
        chk({req, " left"}, got_l, expect_word(f, l));
        chk({req, " right"}, got_r, expect_word(f, r));
    endtask

    // Startup: reset values, partial first half discarded, single pulse, hold.
    task automatic startup_test();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", {23'h0, valid_o}, 24'h0);
        chk("R1 left", left_o, 24'h0);
        chk("R1 right", right_o, 24'h0);
        drive_half(1'b1, 24'hABCDEF, 3'b010, 10, 1'b0);
        drive_half(1'b0, 24'h111111, 3'b010, 32, 1'b0);
        drive_half(1'b1, 24'h5A5A5A, 3'b010, 32, 1'b0);
        drive_half(1'b0, 24'hC3C3C3, 3'b010, 32, 1'b0);
        chk("R11 no early pulse", 24'(vcount), 24'd0);
        drive_half(1'b1, 24'h0, 3'b010, 32, 1'b0);
        chk("R10 one pulse", 24'(vcount), 24'd1);
        chk("R2 left", got_l, 24'h5A5A5A);
        chk("R2 right", got_r, 24'hC3C3C3);
        repeat (40) @(negedge clk);
        chk("R10 no extra pulse", 24'(vcount), 24'd1);
        chk("R10 left held", left_o, 24'h5A5A5A);
        chk("R10 right held", right_o, 24'hC3C3C3);
    endtask

    initial begin
        startup_test();
        frame_test("R2 R8", 3'b010, 24'h800001, 24'h7FFFFE, 32, 1'b1);
        frame_test("R3 R8", 3'b011, 24'h800000, 24'h7FFFFF, 32, 1'b1);
        frame_test("R4 R8", 3'b100, 24'h13579B, 24'hFEDCBA, 32, 1'b1);
        frame_test("R5 R8", 3'b001, 24'h0ABCDE, 24'h080001, 32, 1'b1);
        frame_test("R6", 3'b000, 24'h00F00F, 24'h008001, 32, 1'b1);
        frame_test("R7", 3'b000, 24'h00A5C3, 24'h007FFF, 16, 1'b0);
        frame_test("R9 code101", 3'b101, 24'h246801, 24'hDB97FE, 32, 1'b1);
        frame_test("R9 code110", 3'b110, 24'h369CF0, 24'hC9630F, 32, 1'b0);
        frame_test("R9 code111", 3'b111, 24'h0F0F0F, 24'hF0F0F0, 32, 1'b1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule